// File: doc/BRIEF.md
# Per-Source Programmable Interrupt Controller

This block collects up to 32 external interrupt lines and turns them into two request outputs and one wake output. Each line is first brought into the clock domain through a two-stage synchronizer. A 3-bit code then gives it one of five behaviours: rising edge, falling edge, either edge, active-high level or active-low level. It can also be switched off. Edge events are captured in two separate latch registers, one for rising and one for falling edges. Software clears these latches by writing ones.

An enabled source that is active and unmasked becomes pending. A per-source routing bit then sends it to one of the two request outputs. A separate enable register selects which pending sources may raise the wake output. Every per-source control register has three addresses: one to read it, one where written ones set bits, and one where written ones clear bits. Read-only status registers show, for each request output, which sources are pending on it. A test register that is nonzero forces every enabled, unmasked source pending, so the routing can be checked without driving the pins.

Top module: `sirq_top`

## Requirements
- R1: After a synchronous active-low reset every register reads 0 at every address, and irq_req0, irq_req1 and wake_out are low.
- R2: The trigger code of source n is {cfg2[n], cfg1[n], cfg0[n]}: 000 off, 001 rising edge, 010 falling edge, 011 either edge, 101 high level, 110 low level. The unused codes 100 and 111 behave as off, and an off source never becomes pending.
- R3: Each of the seven control registers k has a read address 3k, a set address 3k+1 and a clear address 3k+2. The registers are cfg0 k=0, cfg1 k=1, cfg2 k=2, mask k=3, wake enable k=4, route k=5 and source select k=6. A 1 written at the set address sets that bit, a 1 written at the clear address clears it, and written 0 bits leave the register unchanged. The source select register is stored and read back only.
- R4: A pending source with its route bit at 1 drives irq_req0. A pending source with its route bit at 0 drives irq_req1. No source ever appears on both.
- R5: The rising latch (read 0x15, clear 0x16) captures a synchronized 0→1 transition of a source whose code is 001 or 011. The falling latch (read 0x17, clear 0x18) captures a 1→0 transition of a source whose code is 010 or 011. Either latch bit becomes visible on the third rising clock edge after the pin changes. It holds until a 1 is written to that bit at the clear address.
- R6: A source whose mask bit is 0 is never pending and reaches no output, whatever its input or latches.
- R7: Address 0x19 reads the pending sources routed to irq_req0 and address 0x1A reads those routed to irq_req1. Each request output is high exactly when its status word is nonzero.
- R8: A level-mode source is pending while its synchronized input is at the active level. This follows the pin two rising clock edges after the pin changes.
- R9: wake_out is high exactly when some pending source has its wake enable bit set.
- R10: The test register at address 0x1B is written and read as a whole word. While it is nonzero, every unmasked source with a valid code (001, 010, 011, 101, 110) is pending regardless of its input. Writing 0 restores normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Raw asynchronous interrupt lines, bit n is source n |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data for bus_addr, combinational |
| irq_req0 | output | 1 | Request output 0 |
| irq_req1 | output | 1 | Request output 1 |
| wake_out | output | 1 | Wake output |

## Verification
The bench builds the block with its default of 32 sources and two synchronizer stages. It sweeps all eight trigger codes on every one of the 32 sources, so each lane is exercised in every mode, including the two unused codes. Each source is routed to an output and given a wake enable that both follow its index. Every combination of mode, route and wake setting therefore appears with a low input, a rising edge, a falling edge, a latch clear, a masked state and test mode. The expected status words and output levels come from the mode code alone.

// File: rtl/sirq_pkg.sv
// Shared constants for the interrupt controller: address map and trigger codes.
// Assumes a 5-bit register address; control register k lives at 3k..3k+2.
package sirq_pkg;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned NUM_RW = 7;   // cfg0, cfg1, cfg2, mask, wake, route, source select

    localparam int unsigned RW_CFG0  = 0;
    localparam int unsigned RW_CFG1  = 1;
    localparam int unsigned RW_CFG2  = 2;
    localparam int unsigned RW_MASK  = 3;
    localparam int unsigned RW_WAKE  = 4;
    localparam int unsigned RW_ROUTE = 5;
    localparam int unsigned RW_SSEL  = 6;

    localparam logic [ADDR_W-1:0] A_RISE_RD  = 5'h15;
    localparam logic [ADDR_W-1:0] A_RISE_CLR = 5'h16;
    localparam logic [ADDR_W-1:0] A_FALL_RD  = 5'h17;
    localparam logic [ADDR_W-1:0] A_FALL_CLR = 5'h18;
    localparam logic [ADDR_W-1:0] A_REQ0_ST  = 5'h19;
    localparam logic [ADDR_W-1:0] A_REQ1_ST  = 5'h1A;
    localparam logic [ADDR_W-1:0] A_TEST     = 5'h1B;

    localparam logic [2:0] TRIG_OFF  = 3'b000;
    localparam logic [2:0] TRIG_RISE = 3'b001;
    localparam logic [2:0] TRIG_FALL = 3'b010;
    localparam logic [2:0] TRIG_BOTH = 3'b011;
    localparam logic [2:0] TRIG_HIGH = 3'b101;
    localparam logic [2:0] TRIG_LOW  = 3'b110;

    // True for the five codes that enable a source.
    function automatic logic trig_valid(input logic [2:0] code);
        return (code == TRIG_RISE) || (code == TRIG_FALL) || (code == TRIG_BOTH) ||
               (code == TRIG_HIGH) || (code == TRIG_LOW);
    endfunction

endpackage

// File: rtl/sirq_sync.sv
// Multi-stage synchronizer for the raw interrupt lines.
// Assumes each line is a slow asynchronous level; no pulse stretching is done.
module sirq_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    // Shift the raw lines through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/sirq_regs.sv
// Register file: seven set/clear/read control registers, test register,
// latch-clear strobes and the read multiplexer.
// Assumes single-cycle writes; reads are combinational on the address.
module sirq_regs
    import sirq_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [W-1:0]              wdata,
    input  logic [W-1:0]              rise_q,
    input  logic [W-1:0]              fall_q,
    input  logic [W-1:0]              st0,
    input  logic [W-1:0]              st1,
    output logic [NUM_RW-1:0][W-1:0]  rw_q,
    output logic [W-1:0]              test_q,
    output logic [W-1:0]              rise_clr,
    output logic [W-1:0]              fall_clr,
    output logic [W-1:0]              rdata
);
    genvar k;
    generate
        for (k = 0; k < NUM_RW; k++) begin : g_rw
            localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(3 * k + 1);
            localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(3 * k + 2);

            // Apply write-one-to-set and write-one-to-clear to register k.
            always_ff @(posedge clk) begin
                if (!rst_n)                     rw_q[k] <= '0;
                else if (we && addr == A_SET)   rw_q[k] <= rw_q[k] | wdata;
                else if (we && addr == A_CLR)   rw_q[k] <= rw_q[k] & ~wdata;
            end

            p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (we && addr == A_SET) |=> ((rw_q[k] & $past(wdata)) == $past(wdata)));
            p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (we && addr == A_CLR) |=> ((rw_q[k] & $past(wdata)) == '0));
            p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !(we && (addr == A_SET || addr == A_CLR)) |=> (rw_q[k] == $past(rw_q[k])));
        end
    endgenerate

    // Store the whole-word test register.
    always_ff @(posedge clk) begin
        if (!rst_n)                    test_q <= '0;
        else if (we && addr == A_TEST) test_q <= wdata;
    end

    // Decode the latch-clear strobes.
    always_comb begin
        rise_clr = (we && addr == A_RISE_CLR) ? wdata : '0;
        fall_clr = (we && addr == A_FALL_CLR) ? wdata : '0;
    end

    // Select the read word for the current address.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_RW; i++)
            if (addr == ADDR_W'(3 * i)) rdata = rw_q[i];
        case (addr)
            A_RISE_RD: rdata = rise_q;
            A_FALL_RD: rdata = fall_q;
            A_REQ0_ST: rdata = st0;
            A_REQ1_ST: rdata = st1;
            A_TEST:    rdata = test_q;
            default:   ;
        endcase
    end
endmodule

// File: rtl/sirq_lane.sv
// One source lane: edge detection, rising/falling latches and pending decision.
// Assumes lvl is already synchronized to clk.
module sirq_lane
    import sirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic [2:0] code,
    input  logic       rise_clr,
    input  logic       fall_clr,
    input  logic       test_on,
    input  logic       mask_en,
    output logic       rise_q,
    output logic       fall_q,
    output logic       pend
);
    logic prev;
    logic arm_rise, arm_fall, hit;

    assign arm_rise = code[0] & ~code[2];
    assign arm_fall = code[1] & ~code[2];

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    // Capture rising edges; a new edge wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rise_q <= 1'b0;
        else if (arm_rise && lvl && !prev)   rise_q <= 1'b1;
        else if (rise_clr)                   rise_q <= 1'b0;
    end

    // Capture falling edges; a new edge wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                          fall_q <= 1'b0;
        else if (arm_fall && !lvl && prev)   fall_q <= 1'b1;
        else if (fall_clr)                   fall_q <= 1'b0;
    end

    // Decide whether the source is active in its trigger mode.
    always_comb begin
        case (code)
            TRIG_RISE: hit = rise_q;
            TRIG_FALL: hit = fall_q;
            TRIG_BOTH: hit = rise_q | fall_q;
            TRIG_HIGH: hit = lvl;
            TRIG_LOW:  hit = ~lvl;
            default:   hit = 1'b0;
        endcase
    end

    assign pend = mask_en & (test_on ? trig_valid(code) : hit);

    p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_valid(code) |-> !pend);
    p_rise_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_q && !rise_clr) |=> rise_q);
    p_fall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_q && !fall_clr) |=> fall_q);
    p_rise_catch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_rise && lvl && !prev) |=> rise_q);
    p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_en |-> !pend);
endmodule

// File: rtl/sirq_top.sv
// Interrupt controller top: synchronizer, per-source lanes, register file,
// routing to two request outputs and wake output.
// Assumes a single clock; bus reads are combinational, writes take one edge.
module sirq_top
    import sirq_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  irq_in,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_SRC-1:0]  bus_wdata,
    output logic [NUM_SRC-1:0]  bus_rdata,
    output logic                irq_req0,
    output logic                irq_req1,
    output logic                wake_out
);
    logic [NUM_SRC-1:0]              lvl;
    logic [NUM_RW-1:0][NUM_SRC-1:0]  rw_q;
    logic [NUM_SRC-1:0]              test_q, rise_clr, fall_clr;
    logic [NUM_SRC-1:0]              rise_q, fall_q, pend, st0, st1;
    logic                            test_on;

    sirq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(irq_in), .dout(lvl)
    );

    sirq_regs #(.W(NUM_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .rise_q(rise_q), .fall_q(fall_q), .st0(st0), .st1(st1),
        .rw_q(rw_q), .test_q(test_q), .rise_clr(rise_clr), .fall_clr(fall_clr),
        .rdata(bus_rdata)
    );

    assign test_on = |test_q;

    genvar n;
    generate
        for (n = 0; n < NUM_SRC; n++) begin : g_lane
            sirq_lane u_lane (
                .clk(clk), .rst_n(rst_n), .lvl(lvl[n]),
                .code({rw_q[RW_CFG2][n], rw_q[RW_CFG1][n], rw_q[RW_CFG0][n]}),
                .rise_clr(rise_clr[n]), .fall_clr(fall_clr[n]),
                .test_on(test_on), .mask_en(rw_q[RW_MASK][n]),
                .rise_q(rise_q[n]), .fall_q(fall_q[n]), .pend(pend[n])
            );
        end
    endgenerate

    // Split pending sources by route bit and combine into the outputs.
    always_comb begin
        st0      = pend & rw_q[RW_ROUTE];
        st1      = pend & ~rw_q[RW_ROUTE];
        irq_req0 = |st0;
        irq_req1 = |st1;
        wake_out = |(pend & rw_q[RW_WAKE]);
    end

    p_route_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st0 & st1) == '0);
    p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st0 | st1) & ~rw_q[RW_MASK]) == '0);
    p_reset_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_req0 && !irq_req1 && !wake_out));
    p_wake_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_out |-> (irq_req0 || irq_req1));
endmodule

// File: tb/sim_sirq_top.sv
module sim_sirq_top;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          bus_we = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic          irq_req0, irq_req1, wake_out;

    int vectors = 0;
    int errors  = 0;

    always #5 clk = ~clk;

    sirq_top #(.NUM_SRC(N), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req0(irq_req0), .irq_req1(irq_req1), .wake_out(wake_out)
    );

    task automatic chk(input logic [95:0] act, input logic [95:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a; #1;
        d = bus_rdata;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Compare both status words and the three outputs against one pending bit.
    task automatic chk_pend(input int s, input bit p, input bit r0, input bit wk, input string tag);
        logic [N-1:0] a0, a1, e0, e1;
        rd(5'h19, a0);
        rd(5'h1A, a1);
        e0 = (p && r0)  ? (N'(1) << s) : '0;
        e1 = (p && !r0) ? (N'(1) << s) : '0;
        chk({a0, a1, 29'd0, irq_req0, irq_req1, wake_out},
            {e0, e1, 29'd0, (p && r0), (p && !r0), (p && wk)}, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: every address reads zero and the outputs are low after reset
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), d);
            chk({64'd0, d}, 96'd0, "R1 reset read");
        end
        chk({93'd0, irq_req0, irq_req1, wake_out}, 96'd0, "R1 reset outputs");

        for (int s = 0; s < N; s++) begin
            for (int c = 0; c < 8; c++) begin
                logic [2:0] code;
                bit rm, fm, hi, lo, vld, r0, wk;
                logic [N-1:0] b;
                code = 3'(c);
                rm = (code == 3'b001) || (code == 3'b011);
                fm = (code == 3'b010) || (code == 3'b011);
                hi = (code == 3'b101);
                lo = (code == 3'b110);
                vld = rm | fm | hi | lo;
                r0 = (s % 2 == 0);
                wk = (s % 3 == 0);
                b = N'(1) << s;

                irq_in = '0;
                wait_edges(3);
                for (int k = 0; k < 6; k++) wr(5'(3 * k + 2), '1);
                wr(5'h16, '1);
                wr(5'h18, '1);
                if (code[0]) wr(5'h01, b);
                if (code[1]) wr(5'h04, b);
                if (code[2]) wr(5'h07, b);
                if (r0) wr(5'h10, b);
                if (wk) wr(5'h0D, b);
                wr(5'h0A, b);
                // R3: writing zeros to set and clear addresses changes nothing
                wr(5'h01, '0);
                wr(5'h02, '0);
                rd(5'h00, d);
                chk({64'd0, d}, {64'd0, (code[0] ? b : N'(0))}, "R3 cfg0 readback");
                rd(5'h09, d);
                chk({64'd0, d}, {64'd0, b}, "R3 mask readback");
                // R3: the source select register is stored and read back only
                wr(5'h13, b);
                rd(5'h12, d);
                chk({64'd0, d}, {64'd0, b}, "R3 source select readback");
                chk_pend(s, 1'b0 | lo, r0, wk, "R3 source select no effect");
                wr(5'h14, b);

                // R8 R2: input held low, only low-level is pending
                chk_pend(s, lo, r0, wk, "R8 R2 R4 R9 input low");

                @(negedge clk); irq_in[s] = 1'b1;
                wait_edges(3);
                chk_pend(s, rm | hi, r0, wk, "R5 R8 R2 after rise");
                rd(5'h15, d);
                chk({64'd0, d}, {64'd0, (rm ? b : N'(0))}, "R5 rise latch");

                @(negedge clk); irq_in[s] = 1'b0;
                wait_edges(3);
                chk_pend(s, rm | fm | lo, r0, wk, "R5 R8 after fall");
                rd(5'h17, d);
                chk({64'd0, d}, {64'd0, (fm ? b : N'(0))}, "R5 fall latch");

                wr(5'h16, b);
                wr(5'h18, b);
                chk_pend(s, lo, r0, wk, "R5 latch clear");

                wr(5'h0B, b);
                chk_pend(s, 1'b0, r0, wk, "R6 masked");
                wr(5'h1B, N'(1));
                chk_pend(s, 1'b0, r0, wk, "R6 R10 masked in test");
                wr(5'h0A, b);
                chk_pend(s, vld, r0, wk, "R10 R7 test forces");
                rd(5'h1B, d);
                chk({64'd0, d}, {64'd0, N'(1)}, "R10 test readback");
                wr(5'h1B, '0);
                chk_pend(s, lo, r0, wk, "R10 normal restored");
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule